// File: doc/BRIEF.md
# Crossbar Clock Generator Channel

This block is a single output channel of a register-programmed clock generator. A source-select field picks one of up to 64 incoming clocks. The chosen clock then passes through two gated dividers in series. The first is a 10-bit pre-divider for large ratios. The second is a 6-bit final divider, which also shapes the duty cycle of the output. In this block every clock is represented as a one-cycle enable pulse in a single system clock domain. The channel delivers its result as an output tick, one per output period, and as an output level with a controlled duty cycle.

Software reaches three words through a plain read/write port. The first is a crossbar word that four neighbouring channels share, and this channel owns one byte of it. The second is a pre-divider word. The third is a final-divider word, which also carries the final gate and a stored synchronous-mode bit. Turning the channel off clears only the final gate. The pre-divider gate keeps whatever value it had.

Top module: `xbar_clk_channel`

## Requirements
- R1: After reset every register field reads 0, `ch_tick` and `ch_lvl` are 0, and `ch_on_sts` is 0.
- R2: The crossbar word sits at address 0x18 + 4·floor(CH_IDX/4). This channel uses the byte at bit offset 8·(CH_IDX mod 4). Within that byte, bits 5:0 hold the source select and bit 6 holds the pre-divider gate. Bit 7 and the bytes of other channels are ignored on write and read as 0.
- R3: The pre-divider word sits at 0x58 + 4·CH_IDX, with its ratio field in bits 9:0. The final-divider word sits at 0x164 + 4·CH_IDX, with the ratio field in bits 5:0, the final gate in bit 6 and the synchronous-mode bit in bit 7. All three fields are stored and read back. Unused bits and unmapped addresses read 0.
- R4: The channel counts only the pulses of `src_en[sel]`, where sel is the source-select field.
- R5: Writing the final-divider word leaves the pre-divider gate unchanged.
- R6: `ch_tick` pulses only while both gates are set. One cycle after the final gate is cleared, `ch_lvl` is 0.
- R7: `ch_on_sts` equals the final gate bit, whatever the value of the pre-divider gate.
- R8: A field value v encodes a ratio of v+1. The output period equals the source period × (pre field+1) × (final field+1). A field value of 0 passes the clock through.
- R9: `ch_tick` is asserted in the first cycle of each output period, and `ch_lvl` is high in that cycle.
- R10: Let N be the final ratio. Within each output period, `ch_lvl` is high for ceil(N/2) pre-divided periods and low for floor(N/2). Even ratios therefore give a 50% duty cycle, and odd ratios give one extra period in the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| src_en | input | NUM_SRC | One enable pulse per source clock edge |
| ch_tick | output | 1 | One pulse at the start of each output period |
| ch_lvl | output | 1 | Output clock level |
| ch_on_sts | output | 1 | Output-enabled status (final gate) |

## Verification
The hardest case to reach is the odd final ratio, where the duty cycle is only visible through the product of all three stages. The stimulus uses a single system clock and gives each source its own fixed pulse spacing. It then chains chosen selects and ratios and measures the whole output period and the high time between consecutive output ticks. The gate split is reached by opening the final gate while the pre-divider gate is closed, and then by closing the channel through the final word alone.

// File: rtl/xch_pkg.sv
package xch_pkg;
    localparam int SEL_W        = 6;
    localparam int PDIV_W       = 10;
    localparam int FDIV_W       = 6;
    localparam int XB_GATE_BIT  = 6;
    localparam int FIN_GATE_BIT = 6;
    localparam int FIN_SYNC_BIT = 7;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic              pre_on;
        logic [PDIV_W-1:0] pre_div;
        logic [FDIV_W-1:0] fin_div;
        logic              fin_on;
        logic              sync_md;
    } ch_cfg_t;
endpackage

// File: rtl/xch_regfile.sv
module xch_regfile
    import xch_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CH_IDX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output ch_cfg_t           cfg_o
);
    localparam int LANE_SH = (CH_IDX % 4) * 8;
    localparam logic [ADDR_W-1:0] XB_A  = ADDR_W'(32'h18 + (CH_IDX / 4) * 4);
    localparam logic [ADDR_W-1:0] PRE_A = ADDR_W'(32'h58 + CH_IDX * 4);
    localparam logic [ADDR_W-1:0] FIN_A = ADDR_W'(32'h164 + CH_IDX * 4);

    ch_cfg_t cfg_d, cfg_q;
    logic    unused_wbits;

    assign unused_wbits = ^wdata;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (addr == XB_A) begin
                cfg_d.sel    = wdata[LANE_SH +: SEL_W];
                cfg_d.pre_on = wdata[LANE_SH + XB_GATE_BIT];
            end
            if (addr == PRE_A) begin
                cfg_d.pre_div = wdata[PDIV_W-1:0];
            end
            if (addr == FIN_A) begin
                cfg_d.fin_div = wdata[FDIV_W-1:0];
                cfg_d.fin_on  = wdata[FIN_GATE_BIT];
                cfg_d.sync_md = wdata[FIN_SYNC_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == XB_A) begin
            rdata[LANE_SH +: SEL_W]          = cfg_q.sel;
            rdata[LANE_SH + XB_GATE_BIT]     = cfg_q.pre_on;
        end
        if (addr == PRE_A) begin
            rdata[PDIV_W-1:0] = cfg_q.pre_div;
        end
        if (addr == FIN_A) begin
            rdata[FDIV_W-1:0]  = cfg_q.fin_div;
            rdata[FIN_GATE_BIT] = cfg_q.fin_on;
            rdata[FIN_SYNC_BIT] = cfg_q.sync_md;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/xch_prediv.sv
module xch_prediv
    import xch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick,
    input  logic              gate_on,
    input  logic [PDIV_W-1:0] ratio,
    output logic              mid_tick
);
    typedef struct packed {
        logic [PDIV_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d     = st_q;
        wrap     = (st_q.cnt >= ratio);
        mid_tick = gate_on && src_tick && wrap;
        if (!gate_on) begin
            st_d.cnt = ratio;
        end else if (src_tick) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + PDIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xch_findiv.sv
module xch_findiv
    import xch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mid_tick,
    input  logic              gate_on,
    input  logic [FDIV_W-1:0] ratio,
    output logic              tick_o,
    output logic              lvl_o
);
    typedef struct packed {
        logic [FDIV_W-1:0] cnt;
        logic              tick;
        logic              lvl;
    } fin_st_t;

    fin_st_t           st_d, st_q;
    logic              wrap;
    logic [FDIV_W-1:0] nxt;
    logic [FDIV_W:0]   half;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        wrap      = (st_q.cnt >= ratio);
        nxt       = wrap ? '0 : st_q.cnt + FDIV_W'(1);
        half      = ({1'b0, ratio} + (FDIV_W+1)'(2)) >> 1;
        if (!gate_on) begin
            st_d.cnt = ratio;
            st_d.lvl = 1'b0;
        end else if (mid_tick) begin
            st_d.cnt  = nxt;
            st_d.tick = wrap;
            st_d.lvl  = ({1'b0, nxt} < half);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign lvl_o  = st_q.lvl;
endmodule

// File: rtl/xbar_clk_channel.sv
module xbar_clk_channel
    import xch_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int CH_IDX  = 5,
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_en,
    output logic               ch_tick,
    output logic               ch_lvl,
    output logic               ch_on_sts
);
    localparam int SRC_SPAN = 1 << SEL_W;
    localparam logic [ADDR_W-1:0] FIN_A = ADDR_W'(32'h164 + CH_IDX * 4);

    ch_cfg_t               cfg;
    logic [SRC_SPAN-1:0]   src_ext;
    logic                  sel_tick;
    logic                  mid_tick;
    logic                  pgate;
    logic                  fgate;
    logic                  fin_wr;

    xch_regfile #(.ADDR_W(ADDR_W), .CH_IDX(CH_IDX)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg_o (cfg)
    );

    assign src_ext  = SRC_SPAN'(src_en);
    assign sel_tick = src_ext[cfg.sel];
    assign pgate    = cfg.pre_on;
    assign fgate    = cfg.fin_on;
    assign fin_wr   = reg_we && (reg_addr == FIN_A);

    xch_prediv u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (sel_tick),
        .gate_on  (pgate),
        .ratio    (cfg.pre_div),
        .mid_tick (mid_tick)
    );

    xch_findiv u_fin (
        .clk      (clk),
        .rst_n    (rst_n),
        .mid_tick (mid_tick),
        .gate_on  (fgate),
        .ratio    (cfg.fin_div),
        .tick_o   (ch_tick),
        .lvl_o    (ch_lvl)
    );

    assign ch_on_sts = fgate;
endmodule

// File: rtl/xch_chk.sv
module xch_chk (
    input logic clk,
    input logic rst_n,
    input logic ch_tick,
    input logic ch_lvl,
    input logic ch_on_sts,
    input logic sel_tick,
    input logic pgate,
    input logic fgate,
    input logic fin_wr,
    input logic wr_gate
);
    p_tick_needs_gates_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_tick |-> $past(pgate && fgate));

    p_tick_needs_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ch_tick |-> $past(sel_tick));

    p_lvl_low_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fgate |=> !ch_lvl);

    p_pgate_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fin_wr |=> $stable(pgate));

    p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fin_wr |=> (ch_on_sts == $past(wr_gate)));

    p_tick_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ch_tick |-> ch_lvl);
endmodule

bind xbar_clk_channel xch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_tick   (ch_tick),
    .ch_lvl    (ch_lvl),
    .ch_on_sts (ch_on_sts),
    .sel_tick  (sel_tick),
    .pgate     (pgate),
    .fgate     (fgate),
    .fin_wr    (fin_wr),
    .wr_gate   (reg_wdata[6])
);

// File: tb/sim_xbar_clk_channel.sv
module sim_xbar_clk_channel;
    localparam int CH     = 5;
    localparam int AW     = 12;
    localparam int NS     = 64;
    localparam int SH     = (CH % 4) * 8;
    localparam logic [AW-1:0] XB  = AW'(32'h18 + (CH / 4) * 4);
    localparam logic [AW-1:0] PRE = AW'(32'h58 + CH * 4);
    localparam logic [AW-1:0] FIN = AW'(32'h164 + CH * 4);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] src_en = '0;
    logic          ch_tick, ch_lvl, ch_on_sts;
    int            n_chk = 0;
    int            n_bad = 0;
    int            tcnt = 0;
    int            cyc = 0;

    always #5 clk = ~clk;

    xbar_clk_channel #(.ADDR_W(AW), .CH_IDX(CH), .NUM_SRC(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_en(src_en),
        .ch_tick(ch_tick), .ch_lvl(ch_lvl), .ch_on_sts(ch_on_sts)
    );

    // source i pulses once every i+1 cycles
    always @(negedge clk) begin
        tcnt <= tcnt + 1;
        for (int i = 0; i < NS; i++) src_en[i] <= ((tcnt % (i + 1)) == 0);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    // measures the period and high time between two successive ticks
    task automatic measure(output int per, output int hi);
        int guard = 0;
        per = 0; hi = 0;
        @(negedge clk);
        while (!ch_tick && guard < 6000) begin @(negedge clk); guard++; end
        do begin
            per++;
            if (ch_lvl) hi++;
            @(negedge clk);
        end while (!ch_tick && per < 6000);
    endtask

    task automatic setup(input int sel, input int pd, input int fd);
        wr(FIN, 32'h0);
        wr(XB, 32'h5A5A_005A | (((sel & 63) | 64) << SH));
        wr(PRE, pd);
        wr(FIN, fd | 64);
    endtask

    task automatic ratio_case(input string req, input int sel, input int pd, input int fd);
        int per, hi, n, m;
        setup(sel, pd, fd);
        measure(per, hi);
        measure(per, hi);
        n = fd + 1;
        m = (sel + 1) * (pd + 1);
        chk({req, " period"}, per, m * n);
        chk({req, " high time"}, hi, m * ((n + 1) / 2));
    endtask

    task automatic t_reset();
        int v;
        rd(XB, v);  chk("R1 crossbar", v, 0);
        rd(PRE, v); chk("R1 prediv", v, 0);
        rd(FIN, v); chk("R1 findiv", v, 0);
        chk("R1 tick", int'(ch_tick), 0);
        chk("R1 level", int'(ch_lvl), 0);
        chk("R1 status", int'(ch_on_sts), 0);
    endtask

    task automatic t_regs();
        int v;
        wr(XB, 32'hFFFF_FFFF);
        rd(XB, v);  chk("R2 lane only, bit7 zero", v, 32'h7F << SH);
        wr(XB, 32'hFFFF_00FF);
        rd(XB, v);  chk("R2 other lanes ignored", v, 0);
        wr(PRE, 32'hFFFF_FFFF);
        rd(PRE, v); chk("R3 prediv field", v, 32'h3FF);
        wr(FIN, 32'hFFFF_FF80);
        rd(FIN, v); chk("R3 sync bit kept", v, 32'h80);
        wr(FIN, 32'hFFFF_FFFF);
        rd(FIN, v); chk("R3 findiv word", v, 32'hFF);
        rd(AW'(0), v); chk("R3 unmapped", v, 0);
        wr(FIN, 0); wr(PRE, 0);
    endtask

    task automatic t_gates();
        int v, seen, per, hi;
        wr(FIN, 0);
        wr(XB, 32'h0);
        wr(PRE, 0);
        wr(FIN, 64);
        seen = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); seen += int'(ch_tick); end
        chk("R6 no tick with pre gate off", seen, 0);
        chk("R7 status with pre gate off", int'(ch_on_sts), 1);
        wr(XB, 64 << SH);
        measure(per, hi);
        chk("R6 runs with both gates", per, 1);
        wr(FIN, 0);
        rd(XB, v);  chk("R5 pre gate kept", v, 64 << SH);
        chk("R7 status off", int'(ch_on_sts), 0);
        chk("R6 level low", int'(ch_lvl), 0);
        seen = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); seen += int'(ch_tick) + int'(ch_lvl); end
        chk("R6 silent when final gate off", seen, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        ratio_case("R8 passthrough src2", 2, 0, 0);
        ratio_case("R10 even ratio", 1, 2, 3);
        ratio_case("R10 odd ratio", 0, 0, 4);
        ratio_case("R4 top source", 63, 0, 1);
        ratio_case("R8 max prediv", 0, 1023, 0);
        ratio_case("R9 R10 odd both", 3, 1, 2);
        t_gates();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule